// File: doc/BRIEF.md
# Paged Word Address Counter

This block keeps the byte address used by a serial memory target to reach its storage array. The address is 17 bits wide and splits into a one-bit bank selector (bit 16), a page row byte (bits 15:8) and a byte offset within a 256-byte page (bits 7:0). Together these cover 512 pages of 256 bytes. The protocol engine loads the three parts one at a time as they arrive on the bus. The bank bit comes from the device address byte, and the row and offset bytes come from the two address bytes that follow it.

After every data byte the engine pulses one of two step strobes. A write step moves only the offset and wraps within the current page. A read step moves the whole address and wraps from the top of the space back to zero. Between steps and between transactions the counter keeps its value. A later current-address read therefore starts at the byte after the last one touched.

Top module: `paged_addr_counter`

## Requirements
- R1: The output address is {bank, row, offset}. The bank bit is bit 16 and is loaded from `bank_in`. The row is bits 15:8 and is loaded from `row_in`. The offset is bits 7:0 and is loaded from `ofs_in`. A load is visible on `addr_o` after the next rising clock edge.
- R2: Each load strobe changes only its own field. The other fields keep their values, and any subset of the three loads may be applied in the same cycle.
- R3: A write step (`step_wr` high, no load) adds one to bits 7:0 modulo 256 and leaves bits 16:8 unchanged, so offset 0xFF goes to 0x00 in the same page.
- R4: A read step (`step_rd` high, `step_wr` low, no load) adds one to the full 17-bit address modulo 2^17. Offset 0xFF carries into the row, and 0x1FFFF goes to 0x00000.
- R5: When any load strobe is high, both step strobes have no effect in that cycle. Loaded fields take the new value and the other fields hold.
- R6: With no load and no step strobe, the address holds its value for any number of cycles.
- R7: When both step strobes are high without a load, the cycle counts as a write step: it uses the page wrap, and bits 16:8 are unchanged.
- R8: A synchronous active-low reset (`rst_n` low at a rising edge) clears the address to 0, whatever the other inputs are.
- R9: `addr_o` is registered. Input changes between clock edges do not change it until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_bank | input | 1 | Load the bank bit from `bank_in` |
| bank_in | input | 1 | Bank bit value (address bit 16) |
| ld_row | input | 1 | Load the row field from `row_in` |
| row_in | input | 8 | Row value (address bits 15:8) |
| ld_ofs | input | 1 | Load the offset field from `ofs_in` |
| ofs_in | input | 8 | Offset value (address bits 7:0) |
| step_wr | input | 1 | Write step: advance the offset, wrapping within the page |
| step_rd | input | 1 | Read step: advance the full address, wrapping to zero |
| addr_o | output | 17 | Current byte address |

## Verification
Corrupt internal state shows up on `addr_o` on the clock edge after the faulty update, because the address register drives the port with no logic in between. A carry that is handled wrongly behaves differently on each step kind. On a write step it shows as a row change at a page boundary. On a read step it shows as a missing row change, or as no return to zero at the top of the space. Both appear one cycle after the step that crosses the boundary. A priority fault between a load and a step shows as an off-by-one value in the cycle after the combined strobe. The bench therefore drives steps across the page boundary and across the top of the address space, and applies combined strobes.

// File: rtl/addr_ctr_pkg.sv
// Package: shared widths and the step classification used by the
// paged address counter and its submodules.
package addr_ctr_pkg;
    localparam int OFS_W  = 8;   // byte offset inside a page
    localparam int ROW_W  = 8;   // page row byte
    localparam int BANK_W = 1;   // bank bit taken from the device byte

    // Kind of advance applied in a cycle.
    typedef enum logic [1:0] {
        STEP_NONE   = 2'd0,
        STEP_PAGE   = 2'd1,  // offset only, wraps within the page
        STEP_LINEAR = 2'd2   // whole address, wraps to zero
    } step_kind_e;
endpackage

// File: rtl/addr_step_ctrl.sv
// Module: addr_step_ctrl
// Decides which advance, if any, applies this cycle.
// Assumes: any load suppresses both steps; write step beats read step.
module addr_step_ctrl
    import addr_ctr_pkg::*;
(
    input  logic       any_load,
    input  logic       step_wr,
    input  logic       step_rd,
    output step_kind_e kind
);
    // Priority: load, then write step, then read step.
    always_comb begin
        if (any_load)     kind = STEP_NONE;
        else if (step_wr) kind = STEP_PAGE;
        else if (step_rd) kind = STEP_LINEAR;
        else              kind = STEP_NONE;
    end
endmodule

// File: rtl/addr_offset_reg.sv
// Module: addr_offset_reg
// Byte offset register: loads, or advances modulo 2^W.
// Assumes: load and advance are never both high (the controller
// guarantees this); wrap_o flags the all-ones value for carry.
module addr_offset_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    output logic [W-1:0] q,
    output logic         wrap_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // Offset state update.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= ld_val;
        else if (adv) q <= q + 1'b1;
    end

    // Carry request for a linear step out of the last offset.
    assign wrap_o = (q == ALL_ONES);
endmodule

// File: rtl/addr_upper_reg.sv
// Module: addr_upper_reg
// Upper address part {bank, row} with one loader per sub-field and
// a carry increment. Assumes: adv is only high when no load is high.
module addr_upper_reg #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_bank,
    input  logic [BANK_W-1:0]       bank_val,
    input  logic                    ld_row,
    input  logic [ROW_W-1:0]        row_val,
    input  logic                    adv,
    output logic [BANK_W+ROW_W-1:0] q
);
    localparam int UW = BANK_W + ROW_W;

    logic [UW-1:0] q_inc;

    // Incremented upper value; bank overflow drops off to zero.
    assign q_inc = q + 1'b1;

    // Upper state update: loads per sub-field, else carry advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld_bank || ld_row) begin
            if (ld_bank) q[UW-1:ROW_W] <= bank_val;
            if (ld_row)  q[ROW_W-1:0]  <= row_val;
        end else if (adv) begin
            q <= q_inc;
        end
    end
endmodule

// File: rtl/paged_addr_counter.sv
// Module: paged_addr_counter (top)
// Word address counter for a paged serial memory target. The address
// is {bank, row, offset}. A write step wraps the offset within its
// page; a read step carries through the whole address.
// Assumes: strobes are synchronous to clk; the state persists until
// reset.
module paged_addr_counter
    import addr_ctr_pkg::*;
#(
    parameter int P_OFS_W  = OFS_W,
    parameter int P_ROW_W  = ROW_W,
    parameter int P_BANK_W = BANK_W,
    localparam int ADDR_W  = P_OFS_W + P_ROW_W + P_BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_bank,
    input  logic [P_BANK_W-1:0] bank_in,
    input  logic                ld_row,
    input  logic [P_ROW_W-1:0]  row_in,
    input  logic                ld_ofs,
    input  logic [P_OFS_W-1:0]  ofs_in,
    input  logic                step_wr,
    input  logic                step_rd,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int UP_W = P_BANK_W + P_ROW_W;

    step_kind_e        kind;
    logic              any_load;
    logic              ofs_adv;
    logic              up_adv;
    logic              ofs_wrap;
    logic [P_OFS_W-1:0] ofs_q;
    logic [UP_W-1:0]    up_q;

    // Any field loader active in this cycle.
    assign any_load = ld_bank | ld_row | ld_ofs;

    addr_step_ctrl u_ctrl (
        .any_load (any_load),
        .step_wr  (step_wr),
        .step_rd  (step_rd),
        .kind     (kind)
    );

    // Both step kinds move the offset; only a linear step carries.
    assign ofs_adv = (kind == STEP_PAGE) || (kind == STEP_LINEAR);
    assign up_adv  = (kind == STEP_LINEAR) && ofs_wrap;

    addr_offset_reg #(.W(P_OFS_W)) u_ofs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_ofs),
        .ld_val (ofs_in),
        .adv    (ofs_adv),
        .q      (ofs_q),
        .wrap_o (ofs_wrap)
    );

    addr_upper_reg #(.BANK_W(P_BANK_W), .ROW_W(P_ROW_W)) u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_bank  (ld_bank),
        .bank_val (bank_in),
        .ld_row   (ld_row),
        .row_val  (row_in),
        .adv      (up_adv),
        .q        (up_q)
    );

    // Output composition: upper part above the offset.
    assign addr_o = {up_q, ofs_q};
endmodule

// Checker: relates the strobes to the next address value.
module addr_ctr_checker #(
    parameter int P_OFS_W  = 8,
    parameter int P_ROW_W  = 8,
    parameter int P_BANK_W = 1,
    localparam int ADDR_W  = P_OFS_W + P_ROW_W + P_BANK_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_bank,
    input logic                ld_row,
    input logic                ld_ofs,
    input logic [P_OFS_W-1:0]  ofs_in,
    input logic                step_wr,
    input logic                step_rd,
    input logic [ADDR_W-1:0]   addr_o
);
    logic              no_ld;
    logic [ADDR_W-1:0] lin_next;
    logic [P_OFS_W-1:0] ofs_next;

    assign no_ld    = !(ld_bank || ld_row || ld_ofs);
    assign lin_next = addr_o + 1'b1;
    assign ofs_next = addr_o[P_OFS_W-1:0] + 1'b1;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> addr_o == '0); // R8

    AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ofs |=> addr_o[P_OFS_W-1:0] == $past(ofs_in)); // R1

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ld && step_wr) |=>
            $stable(addr_o[ADDR_W-1:P_OFS_W]) &&
            addr_o[P_OFS_W-1:0] == $past(ofs_next)); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ld && step_rd && !step_wr) |=> addr_o == $past(lin_next)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ld && !step_wr && !step_rd) |=> $stable(addr_o)); // R6

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_row && !ld_bank && !ld_ofs) |=>
            $stable(addr_o[P_OFS_W-1:0])); // R5
endmodule

bind paged_addr_counter addr_ctr_checker #(
    .P_OFS_W (P_OFS_W),
    .P_ROW_W (P_ROW_W),
    .P_BANK_W(P_BANK_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_bank (ld_bank),
    .ld_row  (ld_row),
    .ld_ofs  (ld_ofs),
    .ofs_in  (ofs_in),
    .step_wr (step_wr),
    .step_rd (step_rd),
    .addr_o  (addr_o)
);

// File: tb/tb_paged_addr_counter.sv
// Scoreboard bench: the driver computes the expected address from the
// requirements and queues it; the monitor compares after each edge.
module tb_paged_addr_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_bank = 1'b0, ld_row = 1'b0, ld_ofs = 1'b0;
    logic [0:0]  bank_in = '0;
    logic [7:0]  row_in = '0, ofs_in = '0;
    logic        step_wr = 1'b0, step_rd = 1'b0;
    logic [16:0] addr_o;

    typedef struct {
        logic [16:0] val;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [16:0] model = '0;
    int          checks = 0;
    int          fails = 0;
    bit          drv_done = 1'b0;

    always #2 clk = ~clk;

    paged_addr_counter dut (
        .clk(clk), .rst_n(rst_n),
        .ld_bank(ld_bank), .bank_in(bank_in),
        .ld_row(ld_row), .row_in(row_in),
        .ld_ofs(ld_ofs), .ofs_in(ofs_in),
        .step_wr(step_wr), .step_rd(step_rd),
        .addr_o(addr_o)
    );

    // Apply one cycle of stimulus; queue the expected next address.
    task automatic drive(input bit rst, input bit lb, input bit bv,
                         input bit lr, input logic [7:0] rv,
                         input bit lo, input logic [7:0] ov,
                         input bit sw, input bit sr, input string tag);
        logic [16:0] nx;
        @(negedge clk);
        rst_n = ~rst; ld_bank = lb; bank_in = bv; ld_row = lr; row_in = rv;
        ld_ofs = lo; ofs_in = ov; step_wr = sw; step_rd = sr;
        nx = model;
        if (rst) nx = '0;                                  // R8
        else if (lb || lr || lo) begin                     // R2, R5
            if (lb) nx[16]   = bv;
            if (lr) nx[15:8] = rv;
            if (lo) nx[7:0]  = ov;
        end else if (sw) nx[7:0] = model[7:0] + 8'd1;      // R3, R7
        else if (sr) nx = model + 17'd1;                   // R4
        #1;
        if (!rst) begin                                    // R9
            checks++;
            if (addr_o !== model) begin
                fails++;
                $display("FAIL R9 mid-cycle actual=%h expected=%h", addr_o, model);
            end
        end
        sb_q.push_back('{val: nx, tag: tag});
        model = nx;
    endtask

    // Monitor: compare one queued item shortly after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (addr_o !== e.val) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, addr_o, e.val);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(400000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: reset clears, even with loads pending
        drive(1, 1, 1, 1, 8'hAA, 1, 8'h55, 0, 0, "R8");
        drive(1, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R8");
        // R1: full load
        drive(0, 1, 1, 1, 8'h23, 1, 8'h45, 0, 0, "R1");
        // R2: single field loads
        drive(0, 0, 0, 0, 8'h00, 1, 8'hFE, 0, 0, "R2");
        drive(0, 0, 0, 1, 8'h7C, 0, 8'h00, 0, 0, "R2");
        drive(0, 1, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
        drive(0, 1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
        // R3: write steps across page end stay in page
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R3");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R3");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R3");
        // R4: read step carries into row
        drive(0, 0, 0, 0, 8'h00, 1, 8'hFF, 0, 0, "R4");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R4");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R4");
        // R4: wrap from top of space to zero
        drive(0, 1, 1, 1, 8'hFF, 1, 8'hFF, 0, 0, "R4");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R4");
        // R4: row carry into bank bit
        drive(0, 1, 0, 1, 8'hFF, 1, 8'hFF, 0, 0, "R4");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R4");
        // R6: idle hold
        for (int i = 0; i < 6; i++)
            drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R6");
        // R5: load with steps active
        drive(0, 0, 0, 1, 8'h11, 0, 8'h00, 1, 1, "R5");
        drive(0, 0, 0, 0, 8'h00, 1, 8'h20, 0, 1, "R5");
        drive(0, 1, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R5");
        // R7: both steps at page end wrap within page
        drive(0, 1, 1, 1, 8'h23, 1, 8'hFF, 0, 0, "R7");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, "R7");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, "R7");
        // R8: reset mid-run
        drive(1, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, "R8");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R6");
        // Long read run across several pages
        drive(0, 0, 0, 1, 8'h05, 1, 8'hF0, 0, 0, "R1");
        for (int i = 0; i < 600; i++)
            drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R4");
        // Long write run stays in page
        for (int i = 0; i < 300; i++)
            drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R3");
        drive(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, "R6");
        @(negedge clk);
        @(negedge clk);
        drv_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule